// File: doc/BRIEF.md
# Byte-Laned Static RAM Stand-In

This block is a clocked, synthesizable replacement for a 16-bit-wide asynchronous static RAM. It exists so that a memory controller can be exercised in a purely synchronous environment. Every control input is active-low and is sampled on the rising clock edge. The inputs are a chip select, a direction input (high means read, low means write), an output enable and one enable for each of the two byte lanes. From these the block decides each cycle whether it is idle in standby, writing, reading or holding its outputs off.

The data return path is split into a lower lane (bits 7:0) and an upper lane (bits 15:8). Each lane has its own registered drive flag, so a wrapper around the block can place real tri-state buffers on each lane. The full array has 262,144 words. For simulation the depth is a parameter, 1024 words by default, and the address width is derived from it.

The block also models the order-dependent rule for the outputs. An access in which the chip select was applied while the direction input already called for a write keeps both lanes off until chip select is released, even if reads are requested later in that access.

Top module: `sram_lane_model`

## Requirements
- R1: Storage holds DEPTH words of 16 bits (default 1024), addressed by an address of clog2(DEPTH) bits. Each word is two 8-bit lanes: the lower lane is data bits 7:0, gated by `lb_n`, and the upper lane is bits 15:8, gated by `ub_n`.
- R2: While `cs_n` is sampled high, the array is never written and both drive flags are low after that edge, whatever the other inputs are, including unknown values.
- R3: A read is a sampled `cs_n`=0, `we_n`=1, `oe_n`=0. After that edge, `rdata` carries the stored word for the addressed location on every driven lane. This is one cycle of latency.
- R4: On a read, `lo_drive` is high after the edge exactly when `lb_n` was low, and `hi_drive` exactly when `ub_n` was low. With both lane enables high, neither lane is driven.
- R5: A write is a sampled `cs_n`=0, `we_n`=0, whatever `oe_n` is. Only lanes whose enable is low take `wdata`, the other lane keeps its stored value, and both drive flags are low after the edge.
- R6: With `cs_n`=0, `we_n`=1 and `oe_n`=1 sampled, both drive flags are low after the edge and the storage is unchanged.
- R7: If `cs_n` is sampled low following a sample with it high, and `we_n` is low in that same sample, both drive flags stay low on every edge until `cs_n` is next sampled high, even for reads. If `cs_n` is applied while `we_n` is high, later reads in the same access drive normally.
- R8: After reset both drive flags are low and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Direction: 1 read, 0 write |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Lower lane enable, active low |
| ub_n | input | 1 | Upper lane enable, active low |
| addr | input | clog2(DEPTH) | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| lo_drive | output | 1 | Lower lane drive flag |
| hi_drive | output | 1 | Upper lane drive flag |

## Verification
On every cycle, the assertions check that standby, writes and reads with the output enable deasserted all leave both lanes undriven one edge later. They also check that a lane is driven only after a sampled read in which that lane was enabled, and that an access locked by the select/direction order never drives. Only the bench scenarios can show that the right word comes back from each address, that a partial write leaves the other lane intact, and that unknown inputs during standby leave the contents unchanged. The same holds for the lock lasting across several cycles and clearing only after chip select is released.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    // access sequencing state: selected in the last sample, access locked off
    typedef struct packed {
        logic sel;
        logic lock;
    } seq_t;

    // registered return path
    typedef struct packed {
        logic [LANES-1:0]  drive;
        logic [WORD_W-1:0] data;
    } ret_t;
endpackage

// File: rtl/sram_mode_decode.sv
`timescale 1ns/1ps
module sram_mode_decode
    import sram_lane_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic             lb_n,
    input  logic             ub_n,
    output logic [LANES-1:0] lane_wr,
    output logic [LANES-1:0] lane_rd
);
    seq_t seq_d, seq_q;

    always_comb begin
        seq_d   = seq_q;
        lane_wr = '0;
        lane_rd = '0;
        if (cs_n == 1'b0) begin
            seq_d.sel = 1'b1;
            if (!seq_q.sel) begin
                seq_d.lock = (we_n == 1'b0);
            end
            if (we_n == 1'b0) begin
                lane_wr = ~{ub_n, lb_n};
            end else if (oe_n == 1'b0 && !seq_d.lock) begin
                lane_rd = ~{ub_n, lb_n};
            end
        end else begin
            seq_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    AST_LOCK_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.lock && cs_n == 1'b0) |-> (lane_rd == '0)); // R7
endmodule

// File: rtl/sram_lane_store.sv
`timescale 1ns/1ps
module sram_lane_store
    import sram_lane_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  lane_wr,
    output logic [WORD_W-1:0] rword
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_wr[g]) begin
                mem[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rword[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/sram_lane_port.sv
`timescale 1ns/1ps
module sram_lane_port
    import sram_lane_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  lane_rd,
    input  logic [WORD_W-1:0] rword,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  drive
);
    ret_t ret_d, ret_q;

    always_comb begin
        ret_d       = ret_q;
        ret_d.drive = lane_rd;
        for (int i = 0; i < LANES; i++) begin
            if (lane_rd[i]) begin
                ret_d.data[i*LANE_W +: LANE_W] = rword[i*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else begin
            ret_q <= ret_d;
        end
    end

    assign rdata = ret_q.data;
    assign drive = ret_q.drive;

    AST_IDLE_LANE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_rd[0] == 1'b0) |=> $stable(rdata[LANE_W-1:0])); // R3
endmodule

// File: rtl/sram_lane_model.sv
`timescale 1ns/1ps
module sram_lane_model
    import sram_lane_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              lb_n,
    input  logic              ub_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              lo_drive,
    output logic              hi_drive
);
    logic [LANES-1:0]  lane_wr;
    logic [LANES-1:0]  lane_rd;
    logic [WORD_W-1:0] rword;
    logic [LANES-1:0]  drive;

    sram_mode_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .lb_n    (lb_n),
        .ub_n    (ub_n),
        .lane_wr (lane_wr),
        .lane_rd (lane_rd)
    );

    sram_lane_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .addr    (addr),
        .wdata   (wdata),
        .lane_wr (lane_wr),
        .rword   (rword)
    );

    sram_lane_port u_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_rd (lane_rd),
        .rword   (rword),
        .rdata   (rdata),
        .drive   (drive)
    );

    assign lo_drive = drive[0];
    assign hi_drive = drive[1];

    AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == 1'b1) |=> (!lo_drive && !hi_drive)); // R2
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == 1'b0 && we_n == 1'b0) |=> (!lo_drive && !hi_drive)); // R5
    AST_OE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == 1'b0 && we_n == 1'b1 && oe_n == 1'b1) |=> (!lo_drive && !hi_drive)); // R6
    AST_LO_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        lo_drive |-> $past(cs_n == 1'b0 && we_n == 1'b1 && oe_n == 1'b0 && lb_n == 1'b0)); // R4
    AST_HI_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        hi_drive |-> $past(cs_n == 1'b0 && we_n == 1'b1 && oe_n == 1'b0 && ub_n == 1'b0)); // R4
endmodule

// File: tb/sram_lane_model_bench.sv
`timescale 1ns/1ps
module sram_lane_model_bench;
    localparam int DEPTH = 64;
    localparam int AW    = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n, we_n, oe_n, lb_n, ub_n;
    logic [AW-1:0] addr;
    logic [15:0]   wdata;
    logic [15:0]   rdata;
    logic          lo_drive, hi_drive;

    int checks = 0;
    int fails  = 0;

    logic [15:0] model [DEPTH];
    bit          r_sel  = 1'b0;
    bit          r_lock = 1'b0;

    always #5 clk = ~clk;

    sram_lane_model #(.DEPTH(DEPTH)) u_sram_lane_model (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .lb_n     (lb_n),
        .ub_n     (ub_n),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .lo_drive (lo_drive),
        .hi_drive (hi_drive)
    );

    function automatic logic [15:0] pat(input int a, input logic [15:0] salt);
        return 16'((a * 16'h01F3) ^ salt);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one sampled access; expectation derived from the requirements
    task automatic step(input logic c, input logic o, input logic w,
                        input logic l, input logic u,
                        input logic [AW-1:0] a, input logic [15:0] d,
                        input string tag);
        logic        exp_lo = 1'b0;
        logic        exp_hi = 1'b0;
        logic [15:0] exp_word = '0;
        @(negedge clk);
        cs_n = c; oe_n = o; we_n = w; lb_n = l; ub_n = u; addr = a; wdata = d;
        if (c === 1'b0) begin
            if (!r_sel) r_lock = (w === 1'b0);
            r_sel = 1'b1;
            if (w === 1'b0) begin
                if (l === 1'b0) model[a][7:0]  = d[7:0];
                if (u === 1'b0) model[a][15:8] = d[15:8];
            end else if (o === 1'b0 && !r_lock) begin
                exp_lo   = (l === 1'b0);
                exp_hi   = (u === 1'b0);
                exp_word = model[a];
            end
        end else begin
            r_sel  = 1'b0;
            r_lock = 1'b0;
        end
        @(posedge clk);
        #1;
        chk(tag, "drive flags {hi,lo}", {14'd0, hi_drive, lo_drive}, {14'd0, exp_hi, exp_lo});
        if (exp_lo) chk(tag, "lower lane data", {8'd0, rdata[7:0]}, {8'd0, exp_word[7:0]});
        if (exp_hi) chk(tag, "upper lane data", {8'd0, rdata[15:8]}, {8'd0, exp_word[15:8]});
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; lb_n = 1'b1; ub_n = 1'b1;
        addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R8", "reset drive flags", {14'd0, hi_drive, lo_drive}, 16'd0);
        chk("R8", "reset rdata", rdata, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // enter with direction high, then fill every word (R1, R5)
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0, "R6");
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, AW'(a), pat(a, 16'hC35A), "R5");

        // every address with every lane combination (R1, R3, R4)
        for (int a = 0; a < DEPTH; a++)
            for (int k = 0; k < 4; k++)
                step(1'b0, 1'b0, 1'b1, k[0], k[1], AW'(a), '0, (k == 0) ? "R3" : "R4");

        // partial writes with output enable varied (R5)
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, a[1], 1'b0, a[0], a[2], AW'(a), pat(a, 16'h6B91), "R5");
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(a), '0, "R1");

        // output enable high: no drive, storage kept (R6)
        for (int a = 0; a < 8; a++) begin
            step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, AW'(a * 7), '0, "R6");
            step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(a * 7), '0, "R6");
        end

        // standby with unknown and write-like inputs (R2)
        for (int a = 0; a < 4; a++)
            step(1'b1, 1'bx, 1'bx, 1'bx, 1'bx, 'x, 'x, "R2");
        for (int a = 0; a < 4; a++)
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, AW'(a), 16'hFFFF, "R2");
        for (int a = 0; a < DEPTH; a++)
            step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(a), '0, "R2");

        // select applied while writing: locked until released (R7)
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, AW'(5), 16'h1234, "R7");
        for (int a = 0; a < 4; a++)
            step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(5), '0, "R7");
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0, "R7");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(5), '0, "R7");

        // select applied while reading, write in the access, then read drives (R7)
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '0, '0, "R7");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, AW'(6), '0, "R7");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, AW'(6), 16'hA5C3, "R7");
        step(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, AW'(6), '0, "R7");
        step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, AW'(6), '0, "R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule